// File: doc/BRIEF.md
# Dual-Bank Coefficient Swap Controller

This block keeps two full sets of filter coefficients, a lower bank and an upper bank, and presents the coefficients of exactly one of them on a read port addressed by tap index. Either bank may be rewritten at any time through a write port, so software or a loader can prepare the idle set while the filter runs from the other.

The choice of bank is a request bit taken either from an external swap pin or from a bank bit held in a small control register. A second control-register bit decides which of the two is used. After reset the pin is the source and the register bank bit is clear. The request is not applied as soon as it changes. It is captured only on a cycle where the sample-clock enable is high, so the whole tap set moves to the new bank on one sample boundary. A one-cycle flag marks every real switch.

Top module: `coef_bank_swap`

## Requirements
- R1: While reset is held (synchronous, active low) the active bank is the lower bank (active_bank = 0), bank_changed is 0, the control register selects the pin as source with the bank bit 0, and every stored coefficient of both banks reads as zero.
- R2: When the source bit of the control register is 1 the request is the swap_pin level; when it is 0 the request is the register bank bit.
- R3: A request of 0 selects the lower bank (bank index 0) and a request of 1 selects the upper bank (bank index 1); rd_data returns the coefficient at rd_addr in the active bank.
- R4: active_bank changes only at a clock edge where sample_en is high; request changes in other cycles have no effect on active_bank or rd_data.
- R5: On a cycle with sample_en high the selected request is sampled and becomes active_bank, visible after that clock edge.
- R6: bank_changed is high for exactly the one cycle following an edge at which active_bank took a different value, and is low after a sample that keeps the same bank.
- R7: A coefficient write to either bank (coef_wr_bank 0 = lower, 1 = upper) is accepted in any cycle; a write to the active bank appears on rd_data from the next cycle, and a write to the idle bank leaves rd_data unchanged.
- R8: After a switch, every tap address reads from the new bank; no tap keeps a value from the old bank.
- R9: A control write (ctl_wr) loads both control bits at the clock edge; a sample in the same cycle still uses the previous register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| swap_pin | input | 1 | External bank request level |
| ctl_wr | input | 1 | Strobe that loads the two control bits |
| ctl_use_pin | input | 1 | New source bit: 1 = pin, 0 = register bank bit |
| ctl_bank_bit | input | 1 | New register bank bit |
| sample_en | input | 1 | High on the system-clock cycle of a sample boundary |
| coef_wr | input | 1 | Coefficient write strobe |
| coef_wr_bank | input | 1 | Bank written: 0 lower, 1 upper |
| coef_wr_addr | input | ADDR_W | Tap index written |
| coef_wr_data | input | COEF_W | Coefficient written |
| rd_addr | input | ADDR_W | Tap index read from the active bank |
| rd_data | output | COEF_W | Coefficient of the active bank at rd_addr |
| active_bank | output | 1 | Bank currently feeding the taps |
| bank_changed | output | 1 | One-cycle flag after a real switch |

## Verification
The assertions assume that swap_pin, the control inputs and the write port are driven from the same clock domain and settle away from the edge, and that tap addresses stay within the tap count. The bench drives every input one nanosecond after a rising edge, keeps all addresses inside the eight-tap default, and sweeps every combination of starting bank, source bit, register bit, pin level and sample enable, so each assertion is exercised without leaving those assumptions.

// File: rtl/coef_swap_pkg.sv
// Package: shared types for the dual-bank coefficient swap controller.
// Assumes: one bit is enough to name a bank (exactly two banks).
package coef_swap_pkg;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef struct packed {
        logic use_pin;   // 1: request from pin, 0: from bank_bit
        logic bank_bit;  // register-held bank request
    } swap_ctl_t;

    localparam swap_ctl_t CTL_RESET = '{use_pin: 1'b1, bank_bit: 1'b0};

endpackage

// File: rtl/swap_ctl_reg.sv
// Module: swap_ctl_reg
// Holds the two control bits and forms the bank request from either the
// external pin or the register bank bit.
// Assumes: swap_pin is synchronous to clk.
module swap_ctl_reg
    import coef_swap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  logic      wr_use_pin,
    input  logic      wr_bank_bit,
    input  logic      swap_pin,
    output swap_ctl_t ctl_q,
    output bank_e     req
);

    // Purpose: load control bits on a write strobe, reset to pin source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else if (wr) begin
            ctl_q <= '{use_pin: wr_use_pin, bank_bit: wr_bank_bit};
        end
    end

    // Purpose: choose the request source from the stored source bit.
    always_comb begin
        if (ctl_q.use_pin) begin
            req = bank_e'(swap_pin);
        end else begin
            req = bank_e'(ctl_q.bank_bit);
        end
    end

endmodule

// File: rtl/bank_select_reg.sv
// Module: bank_select_reg
// Captures the bank request only on sample boundaries so every tap moves
// together, and flags each real change for one cycle.
// Assumes: sample_en is a single-cycle-per-sample qualifier in clk domain.
module bank_select_reg
    import coef_swap_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample_en,
    input  bank_e req,
    output bank_e active,
    output logic  changed
);

    // Purpose: update the active bank and the change flag at sample edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= BANK_LO;
            changed <= 1'b0;
        end else if (sample_en) begin
            active  <= req;
            changed <= (req != active);
        end else begin
            changed <= 1'b0;
        end
    end

endmodule

// File: rtl/coef_bank_store.sv
// Module: coef_bank_store
// Two banks of NUM_TAPS coefficients with one write port and one
// combinational read port on the selected bank.
// Assumes: addresses at or above NUM_TAPS are ignored on write, read as 0.
module coef_bank_store #(
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 16,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_bank,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              rd_bank,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [COEF_W-1:0] rd_data
);

    localparam int NUM_BANKS = 2;

    logic wr_in_range;
    logic rd_in_range;
    logic [NUM_BANKS-1:0][COEF_W-1:0] bank_rd;

    // Purpose: qualify addresses against the tap count.
    always_comb begin
        wr_in_range = (int'(wr_addr) < NUM_TAPS);
        rd_in_range = (int'(rd_addr) < NUM_TAPS);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [COEF_W-1:0] cells [NUM_TAPS];
        logic              bank_hit;

        assign bank_hit = wr && wr_in_range && (int'(wr_bank) == b);

        // Purpose: clear this bank on reset, store one tap per write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int t = 0; t < NUM_TAPS; t++) begin
                    cells[t] <= '0;
                end
            end else if (bank_hit) begin
                cells[wr_addr] <= wr_data;
            end
        end

        assign bank_rd[b] = rd_in_range ? cells[rd_addr] : '0;
    end

    // Purpose: present the tap of the selected bank.
    always_comb begin
        rd_data = bank_rd[rd_bank];
    end

endmodule

// File: rtl/coef_bank_swap.sv
// Module: coef_bank_swap (top)
// Dual-bank coefficient store whose active bank follows a pin or register
// request, applied only on sample boundaries.
// Assumes: all inputs synchronous to clk; filter arithmetic lives elsewhere.
module coef_bank_swap
    import coef_swap_pkg::*;
#(
    parameter  int NUM_TAPS = 8,
    parameter  int COEF_W   = 16,
    localparam int ADDR_W   = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_pin,
    input  logic              ctl_wr,
    input  logic              ctl_use_pin,
    input  logic              ctl_bank_bit,
    input  logic              sample_en,
    input  logic              coef_wr,
    input  logic              coef_wr_bank,
    input  logic [ADDR_W-1:0] coef_wr_addr,
    input  logic [COEF_W-1:0] coef_wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [COEF_W-1:0] rd_data,
    output logic              active_bank,
    output logic              bank_changed
);

    swap_ctl_t ctl_q;
    bank_e     req;
    bank_e     active;

    swap_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (ctl_wr),
        .wr_use_pin  (ctl_use_pin),
        .wr_bank_bit (ctl_bank_bit),
        .swap_pin    (swap_pin),
        .ctl_q       (ctl_q),
        .req         (req)
    );

    bank_select_reg u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .req       (req),
        .active    (active),
        .changed   (bank_changed)
    );

    coef_bank_store #(
        .NUM_TAPS (NUM_TAPS),
        .COEF_W   (COEF_W),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (coef_wr),
        .wr_bank (coef_wr_bank),
        .wr_addr (coef_wr_addr),
        .wr_data (coef_wr_data),
        .rd_bank (active),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign active_bank = active;

endmodule

// File: rtl/coef_bank_swap_chk.sv
// Module: coef_bank_swap_chk
// Property checker for coef_bank_swap, attached by bind below.
// Assumes: inputs are clean and synchronous; addresses within NUM_TAPS.
module coef_bank_swap_chk #(
    parameter int NUM_TAPS = 8,
    parameter int COEF_W   = 16,
    parameter int ADDR_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              swap_pin,
    input logic              sample_en,
    input logic              ctl_src_pin,
    input logic              ctl_reg_bit,
    input logic              coef_wr,
    input logic              coef_wr_bank,
    input logic [ADDR_W-1:0] coef_wr_addr,
    input logic [COEF_W-1:0] coef_wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [COEF_W-1:0] rd_data,
    input logic              active_bank,
    input logic              bank_changed
);

    // R1: reset leaves the lower bank active and no change flag.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (active_bank == 1'b0 && bank_changed == 1'b0));

    // R2, R5: pin source sampled on a sample cycle.
    a_r2_pin_source: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && ctl_src_pin) |=> (active_bank == $past(swap_pin)));

    // R2, R5: register source sampled on a sample cycle.
    a_r2_reg_source: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !ctl_src_pin) |=> (active_bank == $past(ctl_reg_bit)));

    // R4: no sample, no bank movement.
    a_r4_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(active_bank));

    // R6: the flag marks a real switch.
    a_r6_flag_means_switch: assert property (@(posedge clk) disable iff (!rst_n)
        bank_changed |-> (active_bank != $past(active_bank)));

    // R6: every switch is flagged.
    a_r6_switch_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_bank) |-> bank_changed);

    // R7: a write to the active bank is read back on the next cycle.
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_wr && !sample_en && int'(coef_wr_addr) < NUM_TAPS) |=>
        ((rd_addr != $past(coef_wr_addr)) || (active_bank != $past(coef_wr_bank))
         || (rd_data == $past(coef_wr_data))));

endmodule

bind coef_bank_swap coef_bank_swap_chk #(
    .NUM_TAPS (NUM_TAPS),
    .COEF_W   (COEF_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .swap_pin     (swap_pin),
    .sample_en    (sample_en),
    .ctl_src_pin  (ctl_q.use_pin),
    .ctl_reg_bit  (ctl_q.bank_bit),
    .coef_wr      (coef_wr),
    .coef_wr_bank (coef_wr_bank),
    .coef_wr_addr (coef_wr_addr),
    .coef_wr_data (coef_wr_data),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .active_bank  (active_bank),
    .bank_changed (bank_changed)
);

// File: tb/coef_bank_swap_test.sv
`timescale 1ns/1ps
module coef_bank_swap_test;

    localparam int TAPS = 8;
    localparam int CW   = 16;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          swap_pin = 1'b0;
    logic          ctl_wr = 1'b0;
    logic          ctl_use_pin = 1'b0;
    logic          ctl_bank_bit = 1'b0;
    logic          sample_en = 1'b0;
    logic          coef_wr = 1'b0;
    logic          coef_wr_bank = 1'b0;
    logic [AW-1:0] coef_wr_addr = '0;
    logic [CW-1:0] coef_wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          active_bank;
    logic          bank_changed;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [CW-1:0] exp_bank [2][TAPS];
    logic          exp_active;

    always #2.5 clk = ~clk;

    coef_bank_swap #(.NUM_TAPS(TAPS), .COEF_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .swap_pin(swap_pin), .ctl_wr(ctl_wr),
        .ctl_use_pin(ctl_use_pin), .ctl_bank_bit(ctl_bank_bit),
        .sample_en(sample_en), .coef_wr(coef_wr), .coef_wr_bank(coef_wr_bank),
        .coef_wr_addr(coef_wr_addr), .coef_wr_data(coef_wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .active_bank(active_bank),
        .bank_changed(bank_changed)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_coef(logic bank, int addr, logic [CW-1:0] data);
        coef_wr = 1'b1; coef_wr_bank = bank;
        coef_wr_addr = AW'(addr); coef_wr_data = data;
        tick();
        coef_wr = 1'b0;
        exp_bank[bank][addr] = data;
    endtask

    task automatic write_ctl(logic use_pin, logic bit_v);
        ctl_wr = 1'b1; ctl_use_pin = use_pin; ctl_bank_bit = bit_v;
        tick();
        ctl_wr = 1'b0;
    endtask

    task automatic sweep_read(string req);
        for (int t = 0; t < TAPS; t++) begin
            rd_addr = AW'(t);
            #0.2;
            check(req, 32'(rd_data), 32'(exp_bank[exp_active][t]));
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic exp_new;
        // R1: reset state
        for (int t = 0; t < TAPS; t++) begin
            exp_bank[0][t] = '0;
            exp_bank[1][t] = '0;
        end
        exp_active = 1'b0;
        repeat (4) tick();
        check("R1 active", 32'(active_bank), 0);
        check("R1 flag", 32'(bank_changed), 0);
        sweep_read("R1 zero coefs");
        rst_n = 1'b1;
        tick();
        // R1: default source is the pin; pin high then sample selects upper
        swap_pin = 1'b1; sample_en = 1'b1;
        tick();
        sample_en = 1'b0; swap_pin = 1'b0;
        check("R1 default pin source", 32'(active_bank), 1);
        sample_en = 1'b1;
        tick();
        sample_en = 1'b0;
        exp_active = 1'b0;

        // R7: load both banks while lower is active
        for (int t = 0; t < TAPS; t++) begin
            write_coef(1'b0, t, CW'(16'h1000 + t * 3));
            write_coef(1'b1, t, CW'(16'hA000 + t * 7));
        end
        sweep_read("R3 lower bank read");

        // R2 R3 R4 R5 R6 R8: exhaustive sweep over start bank and controls
        for (int s = 0; s < 2; s++) begin
            for (int u = 0; u < 2; u++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int p = 0; p < 2; p++) begin
                        for (int e = 0; e < 2; e++) begin
                            write_ctl(1'b0, s[0]);
                            sample_en = 1'b1;
                            tick();
                            sample_en = 1'b0;
                            exp_active = s[0];
                            write_ctl(u[0], b[0]);
                            swap_pin = p[0]; sample_en = e[0];
                            tick();
                            sample_en = 1'b0;
                            exp_new = e[0] ? (u[0] ? p[0] : b[0]) : s[0];
                            check(e[0] ? "R2 R5 sampled bank" : "R4 held bank",
                                  32'(active_bank), 32'(exp_new));
                            check("R6 flag on switch", 32'(bank_changed),
                                  32'(exp_new != s[0]));
                            swap_pin = ~p[0];
                            tick();
                            check("R6 single pulse", 32'(bank_changed), 0);
                            check("R4 pin change without sample", 32'(active_bank),
                                  32'(exp_new));
                            exp_active = exp_new;
                            sweep_read(exp_new ? "R3 R8 upper taps" : "R3 R8 lower taps");
                        end
                    end
                end
            end
        end

        // R9: control write and sample in the same cycle use old bits
        write_ctl(1'b0, 1'b0);
        sample_en = 1'b1;
        tick();
        sample_en = 1'b0;
        ctl_wr = 1'b1; ctl_use_pin = 1'b0; ctl_bank_bit = 1'b1; sample_en = 1'b1;
        tick();
        ctl_wr = 1'b0; sample_en = 1'b0;
        check("R9 old bits used", 32'(active_bank), 0);
        check("R9 no flag", 32'(bank_changed), 0);
        sample_en = 1'b1;
        tick();
        sample_en = 1'b0;
        check("R9 new bits used", 32'(active_bank), 1);
        check("R9 flag", 32'(bank_changed), 1);
        exp_active = 1'b1;

        // R7: idle-bank write leaves read data, active-bank write shows next cycle
        rd_addr = AW'(2);
        write_coef(1'b0, 2, 16'h5A5A);
        check("R7 idle write hidden", 32'(rd_data), 32'(exp_bank[1][2]));
        write_coef(1'b1, 2, 16'hC3C3);
        check("R7 active write visible", 32'(rd_data), 32'h0000C3C3);
        // R7: write coinciding with a switch to the written bank
        write_ctl(1'b0, 1'b0);
        coef_wr = 1'b1; coef_wr_bank = 1'b0; coef_wr_addr = AW'(5);
        coef_wr_data = 16'h7E11; sample_en = 1'b1;
        tick();
        coef_wr = 1'b0; sample_en = 1'b0;
        exp_bank[0][5] = 16'h7E11;
        exp_active = 1'b0;
        rd_addr = AW'(5);
        #0.2;
        check("R7 R8 write during switch", 32'(rd_data), 32'h00007E11);
        sweep_read("R8 lower after write");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule